// File: doc/BRIEF.md
# Rotate and Shift Unit

This block is the single-bit rotate and shift datapath of an accumulator-style 8-bit processor. Each cycle it takes one operand byte, a carry input and a 3-bit operation code. It produces the rotated or shifted byte combinationally. It also produces a six-bit flag register that is loaded on the clock edge whenever the enable is high.

Seven operations are supported:

- circular rotates in either direction;
- rotates through carry in either direction;
- an arithmetic left shift;
- an arithmetic right shift;
- a logical right shift.

The bit leaving the byte always goes to carry. The operations differ only in what enters the vacated end.

An accumulator-only input selects a reduced flag update. In that mode carry is written and the subtract and half-carry flags are cleared, while sign, zero and parity are kept from before. This matches the short accumulator rotate forms of such processors. Operand fetch and write-back belong to the surrounding core.

Top module: `srs_unit`

## Requirements
- R1: Operation code 0 (circular left rotate) gives result = {operand[6:0], operand[7]} and carry-out = operand[7].
- R2: Operation code 1 (left rotate through carry) gives result = {operand[6:0], carry_in} and carry-out = operand[7].
- R3: Operation code 2 (circular right rotate) gives result = {operand[0], operand[7:1]} and carry-out = operand[0].
- R4: Operation code 3 (right rotate through carry) gives result = {carry_in, operand[7:1]} and carry-out = operand[0].
- R5: Operation code 4 (arithmetic left shift) gives result = {operand[6:0], 0} and carry-out = operand[7].
- R6: Operation code 5 (arithmetic right shift) gives result = {operand[7], operand[7:1]} and carry-out = operand[0].
- R7: Operation code 6 (logical right shift) gives result = {0, operand[7:1]} and carry-out = operand[0], so the sign flag is cleared after a full-mode update.
- R8: The flag bits are laid out as follows: flags[0] carry, flags[1] subtract, flags[2] parity, flags[3] half-carry, flags[4] zero, flags[5] sign. In full mode (acc_only = 0) an update writes these values:
  - carry = carry-out;
  - subtract = 0 and half-carry = 0;
  - parity = 1 exactly when the result has an even number of one bits;
  - zero = 1 exactly when the result is 0x00;
  - sign = result[7].
- R9: In accumulator-only mode (acc_only = 1) an update writes carry = carry-out and clears subtract and half-carry. Sign, zero and parity keep their previous values.
- R10: The flag register is loaded on the rising clock edge when en = 1 and holds its value when en = 0.
- R11: Operation code 7 is reserved. It gives result = operand and leaves the flag register unchanged even when en = 1.
- R12: An active-low asynchronous reset clears all six flag bits to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Flag update enable |
| op_sel | input | 3 | Operation code (0..6 operations, 7 reserved) |
| acc_only | input | 1 | 1 selects the reduced accumulator-only flag update |
| carry_in | input | 1 | Carry entering the through-carry rotates |
| operand | input | 8 | Byte to rotate or shift |
| result | output | 8 | Combinational rotated or shifted byte |
| flags | output | 6 | Registered flags {sign, zero, half, parity, subtract, carry} |

## Verification
The assertions check the register side on every cycle:
- the flags hold when the enable is low or the code is reserved;
- subtract and half-carry are cleared after any update;
- sign, zero and parity are kept in accumulator-only mode;
- carry follows the outgoing MSB on left operations;
- zero tracks the result;
- sign is clear after a logical right shift.

The exact bit that enters each end of the byte, the parity value and the carry on right operations are shown only by the bench. It sweeps every operation, every operand byte and both carry-in values against its own arithmetic model, then runs a random phase that mixes enable and mode.

// File: rtl/srs_pkg.sv
package srs_pkg;

  localparam int unsigned SRS_DW = 8;

  // operation codes; the numeric values are visible at the top ports
  typedef enum logic [2:0] {
    OP_ROL_CIRC  = 3'd0,
    OP_ROL_THRU  = 3'd1,
    OP_ROR_CIRC  = 3'd2,
    OP_ROR_THRU  = 3'd3,
    OP_SHL_ARITH = 3'd4,
    OP_SHR_ARITH = 3'd5,
    OP_SHR_LOGIC = 3'd6,
    OP_RESERVED  = 3'd7
  } srs_op_e;

  // packed MSB first: sign is bit 5, carry is bit 0
  typedef struct packed {
    logic sign;
    logic zero;
    logic half;
    logic parity;
    logic sub;
    logic carry;
  } srs_flags_t;

  localparam int unsigned SRS_FLAG_W = $bits(srs_flags_t);

  // 1 when the vector holds an even number of ones
  function automatic logic even_ones(input logic [SRS_DW-1:0] v);
    return ~(^v);
  endfunction

  function automatic logic is_left(input srs_op_e op);
    return (op == OP_ROL_CIRC) || (op == OP_ROL_THRU) || (op == OP_SHL_ARITH);
  endfunction

  function automatic logic is_valid(input srs_op_e op);
    return op != OP_RESERVED;
  endfunction

endpackage

// File: rtl/srs_bit_engine.sv
module srs_bit_engine
  import srs_pkg::*;
#(
  parameter int unsigned DW = SRS_DW
) (
  input  logic [DW-1:0] opnd,
  input  logic          cin,
  input  srs_op_e       op,
  output logic [DW-1:0] res,
  output logic          cout
);

  localparam int unsigned MSB = DW - 1;

  logic          go_left;
  logic          passthru;
  logic          fill_lo;   // bit entering position 0 on a left move
  logic          fill_hi;   // bit entering position MSB on a right move
  logic [DW-1:0] moved;

  always_comb begin
    go_left  = is_left(op);
    passthru = !is_valid(op);
    unique case (op)
      OP_ROL_CIRC: fill_lo = opnd[MSB];
      OP_ROL_THRU: fill_lo = cin;
      default:     fill_lo = 1'b0;
    endcase
    unique case (op)
      OP_ROR_CIRC:  fill_hi = opnd[0];
      OP_ROR_THRU:  fill_hi = cin;
      OP_SHR_ARITH: fill_hi = opnd[MSB];
      default:      fill_hi = 1'b0;
    endcase
  end

  // per-bit steering: each position picks its lower or upper neighbour
  for (genvar i = 0; i < DW; i++) begin : g_lane
    logic from_lo;
    logic from_hi;
    if (i == 0) begin : g_low_end
      assign from_lo = fill_lo;
    end else begin : g_low_mid
      assign from_lo = opnd[i-1];
    end
    if (i == MSB) begin : g_high_end
      assign from_hi = fill_hi;
    end else begin : g_high_mid
      assign from_hi = opnd[i+1];
    end
    assign moved[i] = go_left ? from_lo : from_hi;
  end

  assign res  = passthru ? opnd : moved;
  assign cout = go_left ? opnd[MSB] : opnd[0];

endmodule

// File: rtl/srs_flag_next.sv
module srs_flag_next
  import srs_pkg::*;
#(
  parameter int unsigned DW = SRS_DW
) (
  input  logic [DW-1:0] res,
  input  logic          cout,
  input  logic          acc_only,
  input  srs_flags_t    prev,
  output srs_flags_t    nxt
);

  logic res_zero;
  logic res_even;

  assign res_zero = (res == '0);
  assign res_even = even_ones(res);

  always_comb begin
    nxt       = prev;
    nxt.carry = cout;
    nxt.sub   = 1'b0;
    nxt.half  = 1'b0;
    if (!acc_only) begin
      nxt.parity = res_even;
      nxt.zero   = res_zero;
      nxt.sign   = res[DW-1];
    end
  end

endmodule

// File: rtl/srs_unit.sv
module srs_unit
  import srs_pkg::*;
#(
  parameter int unsigned DW = SRS_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    op_sel,
  input  logic          acc_only,
  input  logic          carry_in,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic [5:0]    flags
);

  srs_op_e    op;
  logic       eng_cout;
  logic       load_flags;
  srs_flags_t flag_q;
  srs_flags_t flag_d;

  assign op         = srs_op_e'(op_sel);
  assign load_flags = en && is_valid(op);

  srs_bit_engine #(.DW(DW)) i_engine (
    .opnd (operand),
    .cin  (carry_in),
    .op   (op),
    .res  (result),
    .cout (eng_cout)
  );

  srs_flag_next #(.DW(DW)) i_flag_next (
    .res      (result),
    .cout     (eng_cout),
    .acc_only (acc_only),
    .prev     (flag_q),
    .nxt      (flag_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= '0;
    else if (load_flags) flag_q <= flag_d;
  end

  assign flags = flag_q;

  // R10: disabled cycles keep the register
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(flags));

  // R11: reserved code never loads
  a_r11_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == 3'd7) |=> $stable(flags));

  // R8, R9: subtract and half-carry cleared by any update
  a_r8_clear_sub_half: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel != 3'd7) |=> (!flags[1] && !flags[3]));

  // R9: sign, zero and parity survive an accumulator-only update
  a_r9_keep_szp: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel != 3'd7 && acc_only) |=>
      (flags[5] == $past(flags[5]) && flags[4] == $past(flags[4])
       && flags[2] == $past(flags[2])));

  // R8: zero follows the result that was presented
  a_r8_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel != 3'd7 && !acc_only) |=> (flags[4] == ($past(result) == '0)));

  // R7: logical right shift always clears sign
  a_r7_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == 3'd6 && !acc_only) |=> !flags[5]);

  // R1, R2, R5: left operations carry out the old MSB
  a_r1_left_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd4))
      |=> (flags[0] == $past(operand[DW-1])));

endmodule

// File: tb/test_srs_unit.sv
module test_srs_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic       acc_only = 1'b0;
  logic       carry_in = 1'b0;
  logic [7:0] operand = 8'd0;
  logic [7:0] result;
  logic [5:0] flags;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [5:0] exp_flags = 6'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srs_unit i_srs_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .op_sel   (op_sel),
    .acc_only (acc_only),
    .carry_in (carry_in),
    .operand  (operand),
    .result   (result),
    .flags    (flags)
  );

  // returns {carry_out, result} by integer arithmetic
  function automatic logic [8:0] model(input int o, input int a, input int c);
    int r;
    int co;
    case (o)
      0: begin r = (a * 2) % 256 + a / 128;       co = a / 128; end
      1: begin r = (a * 2) % 256 + c;             co = a / 128; end
      2: begin r = a / 2 + (a % 2) * 128;         co = a % 2;   end
      3: begin r = a / 2 + c * 128;               co = a % 2;   end
      4: begin r = (a * 2) % 256;                 co = a / 128; end
      5: begin r = a / 2 + (a / 128) * 128;       co = a % 2;   end
      6: begin r = a / 2;                         co = a % 2;   end
      default: begin r = a;                       co = 0;       end
    endcase
    return {co[0], r[7:0]};
  endfunction

  function automatic logic [5:0] next_flags(input logic [5:0] prev, input bit e,
      input int o, input bit acc, input logic [8:0] m);
    logic [5:0] f;
    int ones;
    f = prev;
    if (e && o != 7) begin
      f[0] = m[8];
      f[1] = 1'b0;
      f[3] = 1'b0;
      if (!acc) begin
        ones = 0;
        for (int b = 0; b < 8; b++) ones += m[b];
        f[2] = (ones % 2 == 0);
        f[4] = (m[7:0] == 8'd0);
        f[5] = m[7];
      end
    end
    return f;
  endfunction

  function automatic string op_tag(input int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h (op=%0d operand=%h cin=%0d acc=%0d en=%0d)",
               tag, act, exp, op_sel, operand, carry_in, acc_only, en);
    end
  endtask

  // one cycle: drive at negedge, check result, clock, check flags
  task automatic step(input bit e, input int o, input int a, input bit c, input bit acc);
    logic [8:0] m;
    string ftag;
    @(negedge clk);
    en = e; op_sel = o[2:0]; operand = a[7:0]; carry_in = c; acc_only = acc;
    m = model(o, a, c);
    #1;
    check(op_tag(o), result, m[7:0]);
    exp_flags = next_flags(exp_flags, e, o, acc, m);
    if (!e)          ftag = "R10";
    else if (o == 7) ftag = "R11";
    else if (acc)    ftag = "R9";
    else if (o == 6) ftag = "R7/R8";
    else             ftag = "R8";
    @(posedge clk);
    #1;
    check(ftag, {2'b00, flags}, {2'b00, exp_flags});
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    // R12: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R12", {2'b00, flags}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners: all-ones through carry, sign clear on logical shift
    step(1, 1, 8'hFF, 0, 0);
    step(1, 3, 8'h00, 1, 0);
    step(1, 6, 8'h80, 0, 0);
    step(1, 5, 8'h81, 0, 0);
    // R9 after a flag-rich update, then R10 and R11 holds
    step(1, 0, 8'h00, 0, 0);
    step(1, 2, 8'h01, 0, 1);
    step(0, 4, 8'hFF, 1, 0);
    step(1, 7, 8'h5A, 1, 0);

    // exhaustive sweep: every code, every byte, both carry values
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++)
          step(1, o, a, c[0], ($urandom % 4) == 0);

    // random phase mixing enable and mode
    for (int k = 0; k < 2000; k++)
      step(($urandom % 4) != 0, $urandom % 8, $urandom % 256,
           $urandom % 2, ($urandom % 3) == 0);

    // R12: reset again in mid-run after non-zero flags
    step(1, 0, 8'h80, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    exp_flags = 6'd0;
    #1;
    check("R12", {2'b00, flags}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule